// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host and an external asynchronous static RAM holding 512K sixteen-bit words. The host offers one transfer at a time over a valid/ready handshake, with a read/write flag, a 19-bit word address, write data and one enable per byte lane. The controller registers the request, drives the RAM's active-low select, output-enable, write-enable and per-lane strobes for as many clock cycles as each timing interval needs, and returns read data with a one-cycle valid pulse.

Every interval is a nanosecond parameter next to a clock-period parameter. Each one is converted to whole cycles, rounded up, with a floor of one cycle. Writes are controlled by write enable. The data bus is driven only after the RAM's outputs have had time to float, and stays stable through the end of the write pulse and one cycle beyond it. After a read, the controller holds output enable high for a turnaround interval before it returns to idle. A request with no byte enabled finishes without any strobe activity.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted, req_ready is 1, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n and mem_lb_n are all 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: In the cycle after a request is accepted (req_valid and req_ready both high at a clock edge), req_ready is 0. It stays 0 until that transfer has fully finished.
- R3: Lane mapping: req_be[0] covers data bits 7:0 and pulls mem_lb_n low, and req_be[1] covers bits 15:8 and pulls mem_ub_n low. A strobe is only ever low while mem_cs_n is low.
- R4: A write holds mem_cs_n and mem_we_n low together for at least ceil(T_WP_NS/CLK_NS) cycles, with mem_oe_n high for the whole pulse.
- R5: mem_dq_oe stays 0 during the first ceil(T_WHZ_NS/CLK_NS) cycles of the write pulse, and it is never 1 while mem_oe_n is low.
- R6: During a write, the driven data equals the accepted write data. It is driven for at least ceil(T_DW_NS/CLK_NS) cycles before mem_we_n rises, stays unchanged while driven, and is still driven in the cycle after mem_we_n rises.
- R7: A read holds mem_cs_n and mem_oe_n low with mem_we_n high for max(ceil(T_RC), ceil(T_AA), ceil(T_OE)) cycles. It samples mem_dq_in at the edge that ends that interval. rsp_valid is a single-cycle pulse carrying the enabled lanes, with disabled lanes reading 0.
- R8: After a read, at least ceil(T_HZ_NS/CLK_NS) cycles with mem_oe_n high pass before mem_dq_oe rises again.
- R9: A request with req_be = 0 never pulls mem_cs_n low and leaves the memory unchanged. If it is a read, it returns rsp_valid with data 0.
- R10: Whenever mem_cs_n is low, mem_addr equals the address accepted with the current request and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | RAM address |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_dq_out | output | 16 | Data toward the RAM pad |
| mem_dq_oe | output | 1 | Pad drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the RAM pad |

## Verification
A sequencer that leaves its wait state one cycle early shows up at the pins within that same transfer. It appears as a write pulse shorter than the minimum, as data driven while the RAM may still be driving, or as a read sample taken before access time. The bench measures all of these in cycles at every write and every read. A wrong lane mapping or a missing mask corrupts the next read-back of the same word, a few cycles later. A stuck ready or a lost transfer hangs the handshake and is caught by the watchdog.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_WAIT,
        ST_WR_DRIVE,
        ST_WR_HOLD,
        ST_WR_REC,
        ST_RD_ACC,
        ST_RD_TURN,
        ST_NULL
    } ctl_state_e;

    // nanoseconds to whole cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_counter.sv
module sram_lane_counter #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R4: an idle counter that is not reloaded stays at zero
    p_counter_rests_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/sram_lane_strobe.sv
module sram_lane_strobe #(
    parameter int unsigned LANES = 2
) (
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] strb_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign strb_n[i] = ~be[i];
    end
endmodule

// File: rtl/sram_lane_rdmask.sv
module sram_lane_rdmask #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] data_in,
    input  logic [LANES-1:0]        be,
    output logic [LANES*LANE_W-1:0] data_out
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign data_out[i*LANE_W +: LANE_W] = be[i] ? data_in[i*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CLK_NS    = 8,
    parameter int unsigned T_WP_NS   = 45,
    parameter int unsigned T_DW_NS   = 25,
    parameter int unsigned T_WC_NS   = 55,
    parameter int unsigned T_WHZ_NS  = 20,
    parameter int unsigned T_RC_NS   = 55,
    parameter int unsigned T_AA_NS   = 55,
    parameter int unsigned T_OE_NS   = 30,
    parameter int unsigned T_HZ_NS   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned LANES    = 2;
    localparam int unsigned LANE_W   = DATA_W / LANES;
    localparam int unsigned WHZ_CYC  = ns_to_cyc(T_WHZ_NS, CLK_NS);
    localparam int unsigned WP_CYC   = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int unsigned DW_CYC   = ns_to_cyc(T_DW_NS, CLK_NS);
    localparam int unsigned WC_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned TURN_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int unsigned RD_CYC   = max2(max2(ns_to_cyc(T_RC_NS, CLK_NS),
                                                 ns_to_cyc(T_AA_NS, CLK_NS)),
                                            ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int unsigned DRV_CYC  = max2(DW_CYC, (WP_CYC > WHZ_CYC) ? WP_CYC - WHZ_CYC : 1);
    localparam int unsigned WR_USED  = WHZ_CYC + DRV_CYC + 1;
    localparam int unsigned REC_CYC  = (WC_CYC > WR_USED) ? WC_CYC - WR_USED : 1;
    localparam int unsigned MAX_CYC  = max2(max2(max2(WHZ_CYC, DRV_CYC), max2(REC_CYC, RD_CYC)),
                                            TURN_CYC);
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic              ready;
        logic              wr;
        logic              cs_n;
        logic              oe_n;
        logic              we_n;
        logic [LANES-1:0]  strb_n;
        logic              dq_oe;
        logic [DATA_W-1:0] dq_out;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic [LANES-1:0] req_strb_n;
    logic [DATA_W-1:0] rd_masked;

    sram_lane_counter #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_lane_strobe #(.LANES(LANES)) u_strobe (
        .be     (req_be),
        .strb_n (req_strb_n)
    );

    sram_lane_rdmask #(.LANES(LANES), .LANE_W(LANE_W)) u_rdmask (
        .data_in  (mem_dq_in),
        .be       (ctl_q.be),
        .data_out (rd_masked)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        tmr_load        = 1'b0;
        tmr_val         = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.ready  = 1'b0;
                    ctl_d.wr     = req_write;
                    ctl_d.addr   = req_addr;
                    ctl_d.dq_out = req_wdata;
                    ctl_d.be     = req_be;
                    if (req_be == '0) begin
                        ctl_d.st = ST_NULL;
                    end else if (req_write) begin
                        ctl_d.st     = ST_WR_WAIT;
                        ctl_d.cs_n   = 1'b0;
                        ctl_d.we_n   = 1'b0;
                        ctl_d.strb_n = req_strb_n;
                        tmr_load     = 1'b1;
                        tmr_val      = CNT_W'(WHZ_CYC - 1);
                    end else begin
                        ctl_d.st     = ST_RD_ACC;
                        ctl_d.cs_n   = 1'b0;
                        ctl_d.oe_n   = 1'b0;
                        ctl_d.strb_n = req_strb_n;
                        tmr_load     = 1'b1;
                        tmr_val      = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_WR_WAIT: begin
                if (tmr_zero) begin
                    ctl_d.st    = ST_WR_DRIVE;
                    ctl_d.dq_oe = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(DRV_CYC - 1);
                end
            end
            ST_WR_DRIVE: begin
                if (tmr_zero) begin
                    ctl_d.st     = ST_WR_HOLD;
                    ctl_d.cs_n   = 1'b1;
                    ctl_d.we_n   = 1'b1;
                    ctl_d.strb_n = '1;
                end
            end
            ST_WR_HOLD: begin
                ctl_d.st    = ST_WR_REC;
                ctl_d.dq_oe = 1'b0;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(REC_CYC - 1);
            end
            ST_WR_REC: begin
                if (tmr_zero) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.ready = 1'b1;
                end
            end
            ST_RD_ACC: begin
                if (tmr_zero) begin
                    ctl_d.st        = ST_RD_TURN;
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_data  = rd_masked;
                    ctl_d.cs_n      = 1'b1;
                    ctl_d.oe_n      = 1'b1;
                    ctl_d.strb_n    = '1;
                    tmr_load        = 1'b1;
                    tmr_val         = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_RD_TURN: begin
                if (tmr_zero) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.ready = 1'b1;
                end
            end
            ST_NULL: begin
                ctl_d.st        = ST_IDLE;
                ctl_d.ready     = 1'b1;
                ctl_d.rsp_valid = !ctl_q.wr;
                ctl_d.rsp_data  = '0;
            end
            default: begin
                ctl_d.st    = ST_IDLE;
                ctl_d.ready = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q           <= '0;
            ctl_q.st        <= ST_IDLE;
            ctl_q.ready     <= 1'b1;
            ctl_q.cs_n      <= 1'b1;
            ctl_q.oe_n      <= 1'b1;
            ctl_q.we_n      <= 1'b1;
            ctl_q.strb_n    <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready  = ctl_q.ready;
    assign rsp_valid  = ctl_q.rsp_valid;
    assign rsp_rdata  = ctl_q.rsp_data;
    assign mem_addr   = ctl_q.addr;
    assign mem_cs_n   = ctl_q.cs_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_lb_n   = ctl_q.strb_n[0];
    assign mem_ub_n   = ctl_q.strb_n[1];
    assign mem_dq_out = ctl_q.dq_out;
    assign mem_dq_oe  = ctl_q.dq_oe;

    // R2: a handshake is followed by a busy cycle
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3: lane strobes only with the chip selected
    p_strobe_needs_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ub_n || !mem_lb_n) |-> !mem_cs_n);

    // R4: write pulse never overlaps output enable
    p_we_excludes_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R5: no pad drive while the RAM may drive
    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    // R5: drive never starts in the same edge as the write pulse
    p_drive_after_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe);

    // R6: driven data holds still
    p_wdata_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    // R6: data is still driven when write enable rises
    p_hold_on_we_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    // R7: response is a single-cycle pulse
    p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: address frozen while selected
    p_addr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;
    localparam int CLK_NS   = 8;
    localparam int WHZ_CYC  = (20 + CLK_NS - 1) / CLK_NS;
    localparam int WP_CYC   = (45 + CLK_NS - 1) / CLK_NS;
    localparam int DW_CYC   = (25 + CLK_NS - 1) / CLK_NS;
    localparam int RD_CYC   = (55 + CLK_NS - 1) / CLK_NS;
    localparam int TURN_CYC = (20 + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    always #4 clk = ~clk;

    sram_lane_ctrl u_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // device model, indexed by the low six address bits
    logic [7:0] dev_lo [64];
    logic [7:0] dev_hi [64];
    logic [7:0] ref_lo [64];
    logic [7:0] ref_hi [64];

    always_comb begin
        mem_dq_in = 16'h5A5A;
        if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            mem_dq_in[7:0]  = !mem_lb_n ? dev_lo[mem_addr[5:0]] : 8'hA5;
            mem_dq_in[15:8] = !mem_ub_n ? dev_hi[mem_addr[5:0]] : 8'hA5;
        end
    end

    logic [18:0] cur_addr;
    logic [1:0]  cur_be;
    logic [15:0] cur_wdata;

    int          wlow = 0, drv = 0, since_rd = 100;
    bit          in_wr = 0, early = 0, after_rd = 0, contend = 0;
    logic [15:0] lat_data;
    logic [1:0]  lat_str;
    logic [18:0] lat_addr;
    int          rd_len = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            // R5: pad drive while RAM output is enabled
            if (!mem_cs_n && !mem_oe_n && mem_dq_oe) contend = 1;
            if (!mem_cs_n && !mem_oe_n) begin
                rd_len++;
                since_rd = 0;
                after_rd = 1;
                // R10 during read
                if (mem_addr != cur_addr)
                    chk(0, "R10", "read address", int'(mem_addr), int'(cur_addr));
            end else begin
                if (rd_len != 0) begin
                    chk(rd_len == RD_CYC, "R7", "read access cycles", rd_len, RD_CYC);
                    rd_len = 0;
                end
                if (since_rd < 100) since_rd++;
            end
            if (mem_dq_oe && after_rd) begin
                chk(since_rd > TURN_CYC, "R8", "turnaround cycles", since_rd - 1, TURN_CYC);
                after_rd = 0;
            end
            if (!mem_cs_n && !mem_we_n) begin
                in_wr = 1;
                wlow++;
                if (!mem_oe_n) contend = 1;
                if (mem_dq_oe) begin
                    drv++;
                    if (wlow <= WHZ_CYC) early = 1;
                    lat_data = mem_dq_out;
                end
                lat_str  = {mem_ub_n, mem_lb_n};
                lat_addr = mem_addr;
            end else if (in_wr) begin
                chk(wlow >= WP_CYC, "R4", "write pulse cycles", wlow, WP_CYC);
                chk(drv >= DW_CYC, "R6", "data setup cycles", drv, DW_CYC);
                chk(mem_dq_oe == 1'b1, "R6", "hold after we rise", int'(mem_dq_oe), 1);
                chk(lat_data == cur_wdata, "R6", "driven data", int'(lat_data), int'(cur_wdata));
                chk(!early, "R5", "early drive", int'(early), 0);
                chk(lat_str == ~cur_be, "R3", "lane strobes", int'(lat_str), int'(~cur_be));
                chk(lat_addr == cur_addr, "R10", "write address", int'(lat_addr), int'(cur_addr));
                if (!lat_str[0]) dev_lo[lat_addr[5:0]] = lat_data[7:0];
                if (!lat_str[1]) dev_hi[lat_addr[5:0]] = lat_data[15:8];
                in_wr = 0; wlow = 0; drv = 0; early = 0;
            end
        end
    end

    // scoreboard monitor
    logic [15:0] exp_q[$];
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7", "unexpected response", int'(rsp_rdata), 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(rsp_rdata == e, "R7", "read data", int'(rsp_rdata), int'(e));
            end
        end
    end

    task automatic issue(input bit w, input logic [18:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        bit sel_seen;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_addr = a; cur_be = be; cur_wdata = d;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        if (w) begin
            if (be[0]) ref_lo[a[5:0]] = d[7:0];
            if (be[1]) ref_hi[a[5:0]] = d[15:8];
        end else begin
            exp_q.push_back({be[1] ? ref_hi[a[5:0]] : 8'h00, be[0] ? ref_lo[a[5:0]] : 8'h00});
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", "ready after accept", int'(req_ready), 0);
        sel_seen = 0;
        while (!req_ready) begin
            if (!mem_cs_n) sel_seen = 1;
            @(negedge clk);
        end
        if (be == 2'b00)
            chk(!sel_seen, "R9", "select on empty request", int'(sel_seen), 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            dev_lo[i] = 8'h00; dev_hi[i] = 8'h00; ref_lo[i] = 8'h00; ref_hi[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
        chk({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == 5'b11111, "R1",
            "strobes in reset", int'({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 31);
        chk(!mem_dq_oe && !rsp_valid, "R1", "drive/valid in reset",
            int'({mem_dq_oe, rsp_valid}), 0);
        rst_n = 1'b1;
        // word writes and reads at both address extremes
        issue(1, 19'h00000, 16'h1234, 2'b11);
        issue(1, 19'h7FFFF, 16'hABCD, 2'b11);
        issue(0, 19'h00000, 16'h0000, 2'b11);
        issue(0, 19'h7FFFF, 16'h0000, 2'b11);
        // R3 single-lane writes
        issue(1, 19'h00000, 16'h77EE, 2'b01);
        issue(1, 19'h00000, 16'h5599, 2'b10);
        issue(0, 19'h00000, 16'h0000, 2'b11);
        issue(0, 19'h00000, 16'h0000, 2'b01);
        issue(0, 19'h00000, 16'h0000, 2'b10);
        // R9 empty requests
        issue(1, 19'h00000, 16'hFFFF, 2'b00);
        issue(0, 19'h00000, 16'h0000, 2'b11);
        issue(0, 19'h00000, 16'h0000, 2'b00);
        // R8 read followed directly by a write
        issue(0, 19'h7FFFF, 16'h0000, 2'b11);
        issue(1, 19'h12345, 16'h0F0F, 2'b11);
        issue(0, 19'h12345, 16'h0000, 2'b11);
        // mixed traffic over several addresses
        for (int i = 1; i <= 8; i++) begin
            logic [18:0] a;
            a = {13'(i * 37), 6'(i + 8)};
            issue(1, a, 16'(i * 16'h1111 + 3), 2'(i % 3 + 1));
            issue(0, a, 16'h0000, 2'b11);
            issue(0, a, 16'h0000, 2'(3 - i % 3));
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "responses outstanding", exp_q.size(), 0);
        chk(!contend, "R5", "bus contention", int'(contend), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(0, "R2", "watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule